// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a selectable prescaled tick. It serves either as a watchdog, which requests a system reset when software fails to reload the count in time, or as a periodic interval timer, which raises an interrupt each time the count wraps. Software reaches it through two byte-wide registers: a count register and a control/status register.

Both registers resist stray writes. A write only takes effect if it is a 16-bit access whose upper byte carries the key for that register. A write of any other size, or with the wrong key, leaves every piece of state as it was.

Reads are 8-bit and return at once. All pins are plain level signals; there is no data stream and no handshake.

Top module: `kwdt_top`

## Requirements
- R1: While `por_n` is low, the count, the control/status register and both outputs are 0.
- R2: While `sys_rst_n` is low and `por_n` is high, the following are cleared: the control/status register, the prescaler, `rst_req`, and through them `irq`. The count keeps its value.
- R3: A write updates the count only when all of these hold:
  - `wr_size` is 1 (16-bit access);
  - `wr_addr` is 0x08;
  - `wr_data[15:8]` is 0x5A.
  
  The count becomes `wr_data[7:0]` on the next edge. This write takes priority over a tick in the same cycle.
- R4: The control/status register is written only by a 16-bit access at 0x0C with `wr_data[15:8]` equal to 0xA5. Its bit layout is:
  - bit 7: enable;
  - bit 6: mode, 1 for watchdog and 0 for interval;
  - bit 3: overflow flag;
  - bits 2:0: clock select;
  - bits 5:4: read as 0.
- R5: These writes change no state:
  - any write whose `wr_size` is 0 (byte) or 2 (32-bit);
  - a 16-bit write with a wrong key;
  - a write to any other offset.
- R6: When enabled, the count rises by one on each cycle in which the low `sel` bits of a 7-bit free-running prescaler are all ones. The prescaler counts from 0 after reset, so the divide ratio is 2^sel. When disabled, the count holds.
- R7: A wrap from 0xFF to 0x00 caused by a tick sets the overflow flag. Only a keyed control write with bit 3 equal to 0 clears the flag; writing 1 never sets it. An overflow in the same cycle as a clearing write wins.
- R8: In watchdog mode, a wrap drives `rst_req` high for exactly one cycle, the cycle after the wrapping edge. The count carries on from 0x00.
- R9: In interval mode, a wrap never raises `rst_req`. `irq` is high whenever the flag is set and the mode is interval. The count keeps running after the wrap.
- R10: `rd_data` is combinational and depends only on `rd_addr`:
  - 0x08 returns the count;
  - 0x0C returns the control/status register;
  - any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | Other reset, active low, asynchronous; spares the count |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| wr_addr | input | 8 | Register offset of the write |
| wr_data | input | 16 | Write data; upper byte carries the key |
| rd_addr | input | 8 | Register offset of the read |
| rd_data | output | 8 | Read data for `rd_addr` |
| rst_req | output | 1 | One-cycle reset request, watchdog mode |
| irq | output | 1 | Interrupt request, interval mode |

## Verification
The bench builds the block with its default parameters:
- a 3-bit clock select;
- a prescaler step of one bit per select code.

This yields divide ratios from 1 to 128 on a 7-bit prescaler, so a full wrap is reachable within a few hundred cycles at the fast settings. The directed phases place reloads at 0xFC and 0xFD, which makes both the watchdog wrap and the interval wrap happen within a few dozen cycles. Random writes then mix keys, sizes and offsets, which also exercises writes that collide with ticks and wraps.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 8;
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CSR = 8'hA5;
  localparam logic [7:0] OFS_CNT = 8'h08;
  localparam logic [7:0] OFS_CSR = 8'h0C;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic             en;
    logic             wd_mode;
    logic             flag;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int SEL_W = 3,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = STEP * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PRE_W; i++)
      mask[i] = (i < (int'(sel) * STEP));
  end

  assign tick = en && (&(pre_q | ~mask));
endmodule

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
  import kwdt_pkg::*;
(
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [7:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        cnt_we,
  output logic        csr_we
);
  logic half_ok;

  assign half_ok = wr_en && (wr_size == SZ_HALF);
  assign cnt_we  = half_ok && (wr_addr == OFS_CNT) && (wr_data[15:8] == KEY_CNT);
  assign csr_we  = half_ok && (wr_addr == OFS_CSR) && (wr_data[15:8] == KEY_CSR);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign wrap = tick && !load && (cnt == CNT_MAX);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int STEP = 1
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [7:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        rst_req,
  output logic        irq
);
  logic             rst_n;
  logic             cnt_we, csr_we, tick, wrap;
  logic [CNT_W-1:0] cnt;
  ctl_t             ctl_q;

  assign rst_n = por_n & sys_rst_n;

  kwdt_keydec u_dec (
    .wr_en   (wr_en),
    .wr_size (wr_size),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt_we  (cnt_we),
    .csr_we  (csr_we)
  );

  kwdt_prescaler #(.SEL_W(SEL_W), .STEP(STEP)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl_q.en),
    .sel   (ctl_q.sel),
    .tick  (tick)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .por_n    (por_n),
    .tick     (tick),
    .load     (cnt_we),
    .load_val (wr_data[CNT_W-1:0]),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap && ctl_q.wd_mode;
      if (csr_we) begin
        ctl_q.en      <= wr_data[7];
        ctl_q.wd_mode <= wr_data[6];
        ctl_q.sel     <= wr_data[SEL_W-1:0];
        ctl_q.flag    <= wrap | (ctl_q.flag & wr_data[3]);
      end else begin
        ctl_q.flag    <= ctl_q.flag | wrap;
      end
    end
  end

  assign irq = ctl_q.flag && !ctl_q.wd_mode;

  always_comb begin
    case (rd_addr)
      OFS_CNT: rd_data = cnt;
      OFS_CSR: rd_data = {ctl_q.en, ctl_q.wd_mode, 2'b00, ctl_q.flag, ctl_q.sel};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
(
  input logic        clk,
  input logic        por_n,
  input logic        sys_rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_size,
  input logic [15:0] wr_data,
  input logic        tick,
  input logic        cnt_we,
  input logic [7:0]  cnt,
  input logic        wd_mode,
  input logic        flag,
  input logic        rst_req
);
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    cnt_we |=> cnt == $past(wr_data[7:0])); // R3
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    wr_en && wr_size != SZ_HALF && !tick |=> $stable(cnt)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    !tick && !cnt_we |=> $stable(cnt)); // R6
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    tick && !cnt_we && cnt == 8'hFF |=> flag && cnt == 8'h00); // R7
  AST_WD_RESET: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    tick && !cnt_we && cnt == 8'hFF && wd_mode |=> rst_req); // R8
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    rst_req |=> !rst_req); // R8
  AST_INTERVAL_QUIET: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    tick && !cnt_we && cnt == 8'hFF && !wd_mode |=> !rst_req); // R9
endmodule

bind kwdt_top kwdt_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sys_rst_n (sys_rst_n),
  .wr_en     (wr_en),
  .wr_size   (wr_size),
  .wr_data   (wr_data),
  .tick      (tick),
  .cnt_we    (cnt_we),
  .cnt       (cnt),
  .wd_mode   (ctl_q.wd_mode),
  .flag      (ctl_q.flag),
  .rst_req   (rst_req)
);

// File: tb/sim_kwdt_top.sv
`timescale 1ns/100ps
module sim_kwdt_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd0;
  logic [7:0]  wr_addr = 8'd0, rd_addr = 8'd0;
  logic [15:0] wr_data = 16'd0;
  logic [7:0]  rd_data;
  logic        rst_req, irq;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R1";

  // reference state
  logic [7:0] m_cnt;
  logic [6:0] m_pre;
  logic       m_en, m_wd, m_flag, m_rst;
  logic [2:0] m_sel;
  logic       tk, cw, sw, ov;

  always #2 clk = ~clk;

  kwdt_top u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_size(wr_size), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req), .irq(irq)
  );

  function automatic logic tick_due(logic en, logic [2:0] sel, logic [6:0] pre);
    logic [6:0] msk;
    msk = 7'((8'd1 << sel) - 8'd1);
    return en && ((pre & msk) == msk);
  endfunction

  function automatic logic [7:0] csr_view();
    return {m_en, m_wd, 2'b00, m_flag, m_sel};
  endfunction

  always @(posedge clk or negedge por_n or negedge sys_rst_n) begin
    if (!por_n) begin
      m_cnt = 0; m_pre = 0; m_en = 0; m_wd = 0; m_flag = 0; m_rst = 0; m_sel = 0;
    end else if (!sys_rst_n) begin
      m_pre = 0; m_en = 0; m_wd = 0; m_flag = 0; m_rst = 0; m_sel = 0;
    end else begin
      tk = tick_due(m_en, m_sel, m_pre);
      cw = wr_en && wr_size == 2'd1 && wr_addr == 8'h08 && wr_data[15:8] == 8'h5A;
      sw = wr_en && wr_size == 2'd1 && wr_addr == 8'h0C && wr_data[15:8] == 8'hA5;
      ov = tk && !cw && m_cnt == 8'hFF;
      m_rst = ov && m_wd;
      m_cnt = cw ? wr_data[7:0] : (tk ? m_cnt + 8'd1 : m_cnt);
      if (sw) begin
        m_flag = ov | (m_flag & wr_data[3]);
        m_en = wr_data[7]; m_wd = wr_data[6]; m_sel = wr_data[2:0];
      end else begin
        m_flag = m_flag | ov;
      end
      m_pre = m_pre + 7'd1;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #0.3 rd_addr = 8'h08;
      #0.3 check({cur_tag, " count"}, rd_data, m_cnt);
      rd_addr = 8'h0C;
      #0.3 check({cur_tag, " control"}, rd_data, csr_view());
      rd_addr = 8'h04;
      #0.3 check("R10 unused offset", rd_data, 8'h00);
      check("R8 rst_req", {7'd0, rst_req}, {7'd0, m_rst});
      check("R9 irq", {7'd0, irq}, {7'd0, m_flag && !m_wd});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] sz, logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_size = sz; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    por_n = 1'b1;
    idle(2);
    cur_tag = "R3";
    bus_wr(2'd1, 8'h08, 16'h5A37); idle(2);
    cur_tag = "R5";
    bus_wr(2'd0, 8'h08, 16'h5A11);
    bus_wr(2'd2, 8'h08, 16'h5A11);
    bus_wr(2'd1, 8'h08, 16'h3311);
    bus_wr(2'd1, 8'h0C, 16'h5A81);
    bus_wr(2'd0, 8'h0C, 16'hA581);
    bus_wr(2'd1, 8'h10, 16'h5A22);
    idle(2);
    cur_tag = "R4 R6";
    bus_wr(2'd1, 8'h0C, 16'hA580); idle(10);
    bus_wr(2'd1, 8'h0C, 16'hA582); idle(20);
    cur_tag = "R7 R9";
    bus_wr(2'd1, 8'h08, 16'h5AFC); idle(30);
    bus_wr(2'd1, 8'h0C, 16'hA58A); idle(3);
    bus_wr(2'd1, 8'h0C, 16'hA582); idle(5);
    cur_tag = "R8";
    bus_wr(2'd1, 8'h0C, 16'hA5C0);
    bus_wr(2'd1, 8'h08, 16'h5AFD); idle(10);
    cur_tag = "R2";
    @(negedge clk); sys_rst_n = 1'b0;
    idle(2); sys_rst_n = 1'b1; idle(3);
    cur_tag = "R3 R4 R5 R6 R7 R8 R9 random";
    for (int k = 0; k < 3000; k++) begin
      logic [1:0]  sz;
      logic [7:0]  a, key;
      logic [15:0] d;
      sz  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 2)) : 2'd1;
      case ($urandom_range(0, 2))
        0: a = 8'h08;
        1: a = 8'h0C;
        default: a = 8'h04;
      endcase
      case ($urandom_range(0, 3))
        0: key = 8'h5A;
        1: key = 8'hA5;
        2: key = (a == 8'h08) ? 8'h5A : 8'hA5;
        default: key = 8'($urandom);
      endcase
      d = {key, 8'($urandom)};
      if (a == 8'h0C && $urandom_range(0, 1) == 1) d[2:1] = 2'b00;
      if ($urandom_range(0, 2) == 0) bus_wr(sz, a, d);
      else idle($urandom_range(1, 4));
    end
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule